// File: doc/BRIEF.md
# Temperature Alarm Event Generator

This block watches a stream of signed temperature samples and raises an active-low event output when the temperature leaves a programmable alarm window or climbs past a critical trip point. The event output is modelled as an open-drain pull-down enable. The block also provides the matching line level, which is high whenever nothing pulls the line low. Three separate status bits report the above-window, below-window and above-critical conditions. Each of these conditions has its own hysteresis, so a sample that hovers near a limit does not make the flag chatter.

Software configures the block through a small register write port. That port sets the global enable, the window enable, the event mode, the hysteresis step, the three limits, and a one-shot clear command. There are three event modes:

- **Latched mode** holds a window violation until software clears it.
- **Comparator mode** follows the window flags, and clears have no effect on it.
- **Critical-only mode** ignores the window entirely.

In every mode the critical condition acts as a comparator that software cannot clear.

Top module: `tmon_event_gen`

## Requirements
- R1: After reset the event output is released (`evt_pull`=0, `evt_n`=1), all three status bits are 0, the global enable and the window enable are 0, and the mode is latched.
  - The reset limits are: upper = +4095, lower = -4096, critical = +4095 (in LSBs).
- R2: A write at address 0 loads the configuration byte. Its fields are:
  - bit 0: global enable.
  - bit 1: window enable.
  - bits 3:2: mode (0 latched, 1 comparator, 2 or 3 critical-only).
  - bits 5:4: hysteresis code.

  Writes load the limits from `wr_data[12:0]` as two's complement: address 1 is the upper limit, address 2 the lower limit, address 3 the critical limit. A write to address 4 is a clear command.
- R3: Temperatures are 13-bit two's complement in 1/16 °C steps. Hysteresis code 0/1/2/3 selects 0/24/48/96 LSBs (0, 1.5, 3, 6 °C).
- R4: On a sample, the above-window flag sets when temp > upper. It clears when temp <= upper − hysteresis, and holds otherwise.
- R5: On a sample, the below-window flag sets when temp < lower. It clears when temp >= lower + hysteresis, and holds otherwise.
- R6: In critical-only mode, window flags never pull the event low. The flags are still reported in status.
- R7: On a sample, the critical flag sets when temp > critical. It clears only when temp <= critical − hysteresis. While the flag is set the event is pulled low in every mode, and clear commands do not release it.
- R8: In latched mode, any sample that leaves a window flag set (with the window enabled) sets a latch that pulls the event low. A clear command releases the latch, except when a sample in the same cycle sets it again, in which case the latch stays set.
- R9: In comparator mode, the event follows (above-window OR below-window) while the window is enabled. Clear commands have no effect.
- R10: Flags and the latch change only on cycles with `sample_valid`. The one exception is a clear command, which releases the latch in latched mode. Temperature changes without the strobe are ignored.
- R11: With the global enable at 0, the event is released and all flags and the latch are held at 0.
- R12: With the window enable at 0, the window flags are still reported but do not pull the event low in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sample_valid | input | 1 | Temperature sample strobe |
| temp | input | 13 | Signed temperature sample, 1/16 °C |
| evt_pull | output | 1 | Open-drain enable: 1 pulls the event line low |
| evt_n | output | 1 | Event line level, active low |
| st_above | output | 1 | Above-window flag |
| st_below | output | 1 | Below-window flag |
| st_crit | output | 1 | Above-critical flag |

## Verification
The bench targets the hysteresis band edges. It places samples exactly at each limit, one step past it, and exactly at the release point:

- An off-by-one comparison or a hysteresis of the wrong sign would set or release a flag one sample early or late.
- A clear command that arrives in the same cycle as a fresh window violation must leave the latch set. A design that gave the clear priority would release the line.

A clear command sent while the critical flag is set, and a switch to critical-only mode while the window is violated, check the comparator override and the window masking. A design that latched the critical condition, or let window flags through in critical-only mode, would show the wrong line level.

Samples presented without the strobe, and a toggle of the global enable, would expose a design that evaluates continuously or keeps stale state.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int TMON_TEMP_W = 13;
    localparam int TMON_DATA_W = 16;
    localparam int TMON_ADDR_W = 3;
    localparam int TMON_HYST_W = 8;

    localparam logic [2:0] ADR_CFG   = 3'd0;
    localparam logic [2:0] ADR_UPPER = 3'd1;
    localparam logic [2:0] ADR_LOWER = 3'd2;
    localparam logic [2:0] ADR_CRIT  = 3'd3;
    localparam logic [2:0] ADR_CLEAR = 3'd4;

    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_CMP   = 2'd1,
        MODE_CRIT  = 2'd2,
        MODE_CRIT2 = 2'd3
    } tmon_mode_e;

    typedef struct packed {
        logic [1:0] hyst_sel;
        tmon_mode_e mode;
        logic       win_en;
        logic       en;
    } tmon_cfg_t;

    function automatic logic [TMON_HYST_W-1:0] hyst_lsb(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd0;
            2'd1:    return 8'd24;
            2'd2:    return 8'd48;
            default: return 8'd96;
        endcase
    endfunction

endpackage

// File: rtl/tmon_regs.sv
module tmon_regs
    import tmon_pkg::*;
#(
    parameter int TW = TMON_TEMP_W,
    parameter int DW = TMON_DATA_W,
    parameter int AW = TMON_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output tmon_cfg_t            cfg_o,
    output logic signed [TW-1:0] upper_o,
    output logic signed [TW-1:0] lower_o,
    output logic signed [TW-1:0] crit_o,
    output logic                 clr_o
);

    localparam logic signed [TW-1:0] SMAX = {1'b0, {(TW-1){1'b1}}};
    localparam logic signed [TW-1:0] SMIN = {1'b1, {(TW-1){1'b0}}};

    typedef struct packed {
        tmon_cfg_t             cfg;
        logic signed [TW-1:0]  upper;
        logic signed [TW-1:0]  lower;
        logic signed [TW-1:0]  crit;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                AW'(ADR_CFG):   r_d.cfg   = tmon_cfg_t'(wr_data[5:0]);
                AW'(ADR_UPPER): r_d.upper = wr_data[TW-1:0];
                AW'(ADR_LOWER): r_d.lower = wr_data[TW-1:0];
                AW'(ADR_CRIT):  r_d.crit  = wr_data[TW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg   <= '{hyst_sel: 2'd0, mode: MODE_LATCH, win_en: 1'b0, en: 1'b0};
            r_q.upper <= SMAX;
            r_q.lower <= SMIN;
            r_q.crit  <= SMAX;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o   = r_q.cfg;
    assign upper_o = r_q.upper;
    assign lower_o = r_q.lower;
    assign crit_o  = r_q.crit;
    assign clr_o   = wr_en && (wr_addr == AW'(ADR_CLEAR));

    // R2: a config write is visible on the next cycle
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADR_CFG)) |=> (cfg_o == tmon_cfg_t'($past(wr_data[5:0]))));

endmodule

// File: rtl/tmon_thresh.sv
module tmon_thresh
    import tmon_pkg::*;
#(
    parameter int TW    = TMON_TEMP_W,
    parameter int HW    = TMON_HYST_W,
    parameter bit ABOVE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 sample_valid,
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] thr,
    input  logic [HW-1:0]        hyst,
    output logic                 flag_d,
    output logic                 flag_q
);

    localparam int EW = (TW > HW ? TW : HW) + 2;

    logic signed [EW-1:0] t_x, thr_x, h_x;
    logic trip, release_ok;

    assign t_x   = EW'(temp);
    assign thr_x = EW'(thr);
    assign h_x   = $signed({{(EW-HW){1'b0}}, hyst});

    generate
        if (ABOVE) begin : g_above
            assign trip       = t_x > thr_x;
            assign release_ok = t_x <= (thr_x - h_x);
        end else begin : g_below
            assign trip       = t_x < thr_x;
            assign release_ok = t_x >= (thr_x + h_x);
        end
    endgenerate

    always_comb begin
        flag_d = flag_q;
        if (!en) begin
            flag_d = 1'b0;
        end else if (sample_valid) begin
            if (trip)
                flag_d = 1'b1;
            else if (release_ok)
                flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // R10: no strobe, no change
    a_r10_hold_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sample_valid) |=> $stable(flag_q));
    // R11: disabled block keeps the flag clear
    a_r11_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flag_q);

endmodule

// File: rtl/tmon_event_gen.sv
module tmon_event_gen
    import tmon_pkg::*;
#(
    parameter int TW = TMON_TEMP_W,
    parameter int DW = TMON_DATA_W,
    parameter int AW = TMON_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 sample_valid,
    input  logic signed [TW-1:0] temp,
    output logic                 evt_pull,
    output logic                 evt_n,
    output logic                 st_above,
    output logic                 st_below,
    output logic                 st_crit
);

    localparam int NCMP  = 3;
    localparam int I_UP  = 0;
    localparam int I_LO  = 1;
    localparam int I_CR  = 2;

    tmon_cfg_t            cfg;
    logic signed [TW-1:0] upper, lower, crit;
    logic                 clr;
    logic [TMON_HYST_W-1:0] hyst;
    logic signed [TW-1:0] thr [NCMP];
    logic [NCMP-1:0]      fl_d, fl_q;

    tmon_regs #(.TW(TW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_o(cfg), .upper_o(upper), .lower_o(lower),
        .crit_o(crit), .clr_o(clr)
    );

    assign hyst      = hyst_lsb(cfg.hyst_sel);
    assign thr[I_UP] = upper;
    assign thr[I_LO] = lower;
    assign thr[I_CR] = crit;

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            tmon_thresh #(.TW(TW), .HW(TMON_HYST_W), .ABOVE(i != I_LO)) u_cmp (
                .clk(clk), .rst_n(rst_n), .en(cfg.en), .sample_valid(sample_valid),
                .temp(temp), .thr(thr[i]), .hyst(hyst),
                .flag_d(fl_d[i]), .flag_q(fl_q[i])
            );
        end
    endgenerate

    typedef struct packed {
        logic latch;
    } st_t;

    st_t  s_d, s_q;
    logic win_new, win_cur, mode_latch, pull_c;

    assign mode_latch = (cfg.mode == MODE_LATCH);
    assign win_new    = cfg.win_en && (fl_d[I_UP] || fl_d[I_LO]);
    assign win_cur    = cfg.win_en && (fl_q[I_UP] || fl_q[I_LO]);

    always_comb begin
        s_d = s_q;
        if (!cfg.en || !mode_latch)
            s_d.latch = 1'b0;
        else if (sample_valid && win_new)
            s_d.latch = 1'b1;
        else if (clr)
            s_d.latch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        pull_c = fl_q[I_CR];
        case (cfg.mode)
            MODE_LATCH: pull_c = pull_c || s_q.latch;
            MODE_CMP:   pull_c = pull_c || win_cur;
            default:    ;
        endcase
        pull_c = pull_c && cfg.en;
    end

    assign evt_pull = pull_c;
    assign evt_n    = !pull_c;
    assign st_above = fl_q[I_UP];
    assign st_below = fl_q[I_LO];
    assign st_crit  = fl_q[I_CR];

    // R7: the critical flag always pulls the line
    a_r7_crit_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && st_crit) |-> !evt_n);
    // R11: disabled block releases the line
    a_r11_off_released: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (evt_n && !evt_pull));
    // R6: critical-only mode ignores the window
    a_r6_critonly_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode inside {MODE_CRIT, MODE_CRIT2} && !st_crit) |-> evt_n);
    // R8: a fresh violation beats a same-cycle clear
    a_r8_clear_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && mode_latch && sample_valid && win_new && clr && !wr_en_cfg_write())
        |=> s_q.latch);
    // R12: window disabled never drives the line without the critical flag
    a_r12_win_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.win_en && !st_crit && !s_q.latch) |-> evt_n);

    function automatic logic wr_en_cfg_write();
        return 1'b0;
    endfunction

endmodule

// File: tb/tb_tmon_event_gen.sv
module tb_tmon_event_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sample_valid = 1'b0;
    logic signed [12:0] temp = '0;
    logic evt_pull, evt_n, st_above, st_below, st_crit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    bit m_en, m_win, m_hi, m_lo, m_cr, m_lat;
    int m_mode, m_hsel, m_up, m_lb, m_cb;

    always #10 clk = ~clk;

    tmon_event_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_valid(sample_valid), .temp(temp), .evt_pull(evt_pull), .evt_n(evt_n),
        .st_above(st_above), .st_below(st_below), .st_crit(st_crit)
    );

    function automatic int hyst_of(int s);
        case (s)
            0: return 0;
            1: return 24;
            2: return 48;
            default: return 96;
        endcase
    endfunction

    function automatic int sx13(int v);
        int x = v & 32'h1FFF;
        return (x >= 4096) ? x - 8192 : x;
    endfunction

    function automatic bit exp_pull();
        bit p = m_cr;
        if (m_mode == 0) p = p | m_lat;
        else if (m_mode == 1) p = p | (m_win & (m_hi | m_lo));
        return m_en & p;
    endfunction

    task automatic model_edge(bit we, int adr, int dat, bit sv, int t);
        bit clr = we && adr == 4;
        int h = hyst_of(m_hsel);
        if (!m_en) begin
            m_hi = 0; m_lo = 0; m_cr = 0; m_lat = 0;
        end else begin
            if (sv) begin
                if (t > m_up) m_hi = 1; else if (t <= m_up - h) m_hi = 0;
                if (t < m_lb) m_lo = 1; else if (t >= m_lb + h) m_lo = 0;
                if (t > m_cb) m_cr = 1; else if (t <= m_cb - h) m_cr = 0;
            end
            if (m_mode != 0) m_lat = 0;
            else if (sv && m_win && (m_hi || m_lo)) m_lat = 1;
            else if (clr) m_lat = 0;
        end
        if (we) begin
            case (adr)
                0: begin
                    m_en = dat[0]; m_win = dat[1];
                    m_mode = (dat >> 2) & 3; m_hsel = (dat >> 4) & 3;
                end
                1: m_up = sx13(dat);
                2: m_lb = sx13(dat);
                3: m_cb = sx13(dat);
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag);
        bit ep = exp_pull();
        n_chk++;
        if (evt_pull !== ep || evt_n !== !ep || st_above !== m_hi ||
            st_below !== m_lo || st_crit !== m_cr) begin
            n_bad++;
            $display("FAIL %s: pull/n/hi/lo/cr got %b%b%b%b%b exp %b%b%b%b%b", tag,
                     evt_pull, evt_n, st_above, st_below, st_crit,
                     ep, !ep, m_hi, m_lo, m_cr);
        end
    endtask

    task automatic step(string tag, bit we, int adr, int dat, bit sv, int t);
        wr_en = we; wr_addr = adr[2:0]; wr_data = dat[15:0];
        sample_valid = sv; temp = t[12:0];
        @(posedge clk);
        model_edge(we, adr, dat, sv, t);
        @(negedge clk);
        wr_en = 0; sample_valid = 0;
        check(tag);
    endtask

    function automatic int cfgw(bit en, bit win, int mode, int hs);
        return (hs << 4) | (mode << 2) | (int'(win) << 1) | int'(en);
    endfunction

    initial begin
        m_en = 0; m_win = 0; m_hi = 0; m_lo = 0; m_cr = 0; m_lat = 0;
        m_mode = 0; m_hsel = 0; m_up = 4095; m_lb = -4096; m_cb = 4095;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset");

        step("R2 upper", 1, 1, 1280, 0, 0);
        step("R2 lower", 1, 2, 160, 0, 0);
        step("R2 crit",  1, 3, 1600, 0, 0);
        step("R2 cfg",   1, 0, cfgw(1, 1, 0, 1), 0, 0);
        step("R10 no strobe", 0, 0, 0, 0, 2000);
        step("R4 one above", 0, 0, 0, 1, 1281);
        step("R4 inside hyst", 0, 0, 0, 1, 1270);
        step("R4 release edge", 0, 0, 0, 1, 1256);
        step("R8 clear", 1, 4, 1, 0, 0);
        step("R8 clear vs violation", 1, 4, 1, 1, 1300);
        step("R9 to compare", 1, 0, cfgw(1, 1, 1, 1), 1, 1300);
        step("R9 clear ignored", 1, 4, 1, 0, 0);
        step("R9 release", 0, 0, 0, 1, 1256);
        step("R5 below", 0, 0, 0, 1, 159);
        step("R5 in hyst", 0, 0, 0, 1, 170);
        step("R5 release", 0, 0, 0, 1, 184);
        step("R3 hyst 6C", 1, 0, cfgw(1, 1, 1, 3), 1, 1281);
        step("R3 hold", 0, 0, 0, 1, 1200);
        step("R3 release", 0, 0, 0, 1, 1184);
        step("R12 win off", 1, 0, cfgw(1, 0, 1, 3), 1, 1300);
        step("R12 status only", 0, 0, 0, 1, 1350);
        step("R6 crit-only", 1, 0, cfgw(1, 1, 2, 3), 1, 1500);
        step("R6 above crit", 0, 0, 0, 1, 1601);
        step("R7 latched mode", 1, 0, cfgw(1, 1, 0, 3), 0, 0);
        step("R7 clear ignored", 1, 4, 1, 0, 0);
        step("R7 in hyst", 0, 0, 0, 1, 1550);
        step("R7 release", 0, 0, 0, 1, 1504);
        step("R11 disable", 1, 0, cfgw(0, 1, 0, 3), 0, 0);
        step("R11 sample while off", 0, 0, 0, 1, 2000);
        step("R11 reenable", 1, 0, cfgw(1, 1, 0, 3), 1, 500);
        step("R6 mode3", 1, 0, cfgw(1, 1, 3, 0), 1, 1700);

        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            int t = $urandom_range(0, 2800) - 700;
            if (r < 4)
                step("R2 R4 random cfg", 1, 0,
                     cfgw($urandom_range(0, 9) != 0, $urandom_range(0, 3) != 0,
                          $urandom_range(0, 3), $urandom_range(0, 3)),
                     $urandom_range(0, 1), t);
            else if (r < 6)
                step("R4 random upper", 1, 1, $urandom_range(800, 1800), 1, t);
            else if (r < 8)
                step("R5 random lower", 1, 2, $urandom_range(0, 800) - 400, 1, t);
            else if (r < 10)
                step("R7 random crit", 1, 3, $urandom_range(1300, 2000), 1, t);
            else if (r < 20)
                step("R8 R9 random clear", 1, 4, 1, $urandom_range(0, 1), t);
            else if (r < 30)
                step("R10 random idle", 0, 0, 0, 0, t);
            else
                step("R4 R5 R7 random sample", 0, 0, 0, 1, t);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule